// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is a watchdog for a small microcontroller core. A counter advances once per machine cycle, signalled by a one-clock strobe from the core. If the counter is not cleared in time, the block drives a reset output high for a fixed number of oscillator clocks. The watchdog starts out disabled. Software turns it on by writing a two-byte key sequence to a write-only service register on the special-function register bus. Writing the same pair again clears the counter. Software cannot turn it off. Only a hardware reset or its own overflow pulse disables it.

The counter freezes in power-down. It also stays frozen after a wake through the external interrupt line until that active-low line returns high. In idle mode it keeps counting unless an idle-freeze control bit is set. Defaults: a 13-bit counter, which overflows after 8191 counted machine cycles; a 98-clock reset pulse; service address 0xA6; keys 0x1E then 0xE1.

Top module: `seq_watchdog`

## Requirements
- R1: After reset, `rstOut` is low and the watchdog is disabled. Machine-cycle strobes then never produce a pulse until the key sequence is written.
- R2: A write of data KEY_A (default 0x1E) to address SVC_ADDR (default 0xA6), followed by a next write to that address of KEY_B (default 0xE1), enables the watchdog with its counter at zero.
- R3: When enabled, the edge that samples the (2^CNT_W − 1)-th counted machine cycle since the last clear starts the reset pulse. `rstOut` is high from that edge onward.
- R4: A completed key sequence while enabled clears the counter. If it completes on the same cycle as the final counted machine cycle, the clear wins and no pulse starts.
- R5: Software cannot disable the watchdog. The overflow pulse returns it to disabled with the counter cleared, so a fresh key sequence is needed.
- R6: `rstOut` stays high for exactly PULSE_LEN clocks (default 98). Writes made during the pulse are ignored.
- R7: The counter advances only on clocks where `mcStrobe` is high.
- R8: While `pdMode` is high the counter does not advance.
- R9: After `pdMode` falls, the counter stays frozen while `wakeIntN` is low. It resumes once `wakeIntN` has been seen high.
- R10: While `idleMode` is high, the counter advances if `idleFreeze` is 0 and stays frozen if `idleFreeze` is 1.
- R11: After KEY_A, a write of any other value to SVC_ADDR aborts the sequence, and a later KEY_B alone does nothing. A repeated KEY_A keeps the sequence armed. KEY_B with no preceding KEY_A does nothing.
- R12: Writes to any address other than SVC_ADDR change neither the sequence tracker nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| mcStrobe | input | 1 | One-clock machine-cycle strobe |
| sfrAddr | input | ADDR_W | Register bus write address |
| sfrData | input | DATA_W | Register bus write data |
| sfrWe | input | 1 | Register bus write strobe |
| idleMode | input | 1 | Core is in idle mode |
| pdMode | input | 1 | Core is in power-down mode |
| idleFreeze | input | 1 | 1 freezes the counter during idle |
| wakeIntN | input | 1 | Active-low external interrupt level used for wake |
| rstOut | output | 1 | Watchdog reset pulse, active high |

## Verification
The sharpest collision is a service write that completes on the same clock as the machine cycle that would overflow the counter. The bench arms the sequence with KEY_A while the strobe is held low. It then runs the counter to one short of the limit and presents KEY_B together with the final strobe. The check is that no pulse follows, and that a full 2^CNT_W − 1 further counted cycles are needed before the next pulse. A second meeting point is a key write that lands inside the reset pulse. That write must be lost, and the watchdog must stay disabled after the pulse ends.

// File: rtl/seq_wdt_pkg.sv
`timescale 1ns/1ps
package seq_wdt_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic clr;  // zero the counter (takes priority)
    logic inc;  // advance the counter by one
  } wdtStrb_t;
endpackage

// File: rtl/seq_wdt_dp.sv
`timescale 1ns/1ps
module seq_wdt_dp
  import seq_wdt_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic     clk,
  input  logic     rstN,
  input  wdtStrb_t strb,
  output logic     atLimit
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (strb.clr) cnt <= '0;
    else if (strb.inc) cnt <= cnt + STEP;
  end

  // next counted cycle would reach the all-ones value
  assign atLimit = (cnt == LAST);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inc && !strb.clr) |=> $stable(cnt));

  // R3
  advance_by_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.clr) |=> (cnt == $past(cnt) + STEP));

  // R4
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0));
endmodule

// File: rtl/seq_wdt_ctrl.sv
`timescale 1ns/1ps
module seq_wdt_ctrl
  import seq_wdt_pkg::*;
#(
  parameter int                PULSE_LEN = 98,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 'hA6,
  parameter logic [DATA_W-1:0] KEY_A     = 'h1E,
  parameter logic [DATA_W-1:0] KEY_B     = 'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrData,
  input  logic              sfrWe,
  input  logic              idleMode,
  input  logic              pdMode,
  input  logic              idleFreeze,
  input  logic              wakeIntN,
  input  logic              atLimit,
  output wdtStrb_t          strb,
  output logic              rstOut
);
  localparam int            PW   = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic          armed;
  logic          enabled;
  logic          wakeHold;
  logic [PW-1:0] pulseCnt;

  logic wrSvc, inPulse, frozen, countOk, svc, ovf;

  always_comb begin
    wrSvc   = sfrWe && (sfrAddr == SVC_ADDR);
    inPulse = (pulseCnt != '0);
    frozen  = pdMode || wakeHold || (idleMode && idleFreeze);
    countOk = enabled && mcStrobe && !frozen && !inPulse;
    svc     = wrSvc && armed && (sfrData == KEY_B) && !inPulse;
    ovf     = countOk && atLimit && !svc;
    strb.clr = svc || ovf || inPulse;
    strb.inc = countOk && !strb.clr;
  end

  // key sequence tracker: only writes to the service address matter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (inPulse) armed <= 1'b0;
    else if (wrSvc)   armed <= (sfrData == KEY_A);
  end

  // enable: set by the key pair, cleared only by reset or overflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enabled <= 1'b0;
    else if (ovf || inPulse) enabled <= 1'b0;
    else if (svc)            enabled <= 1'b1;
  end

  // freeze after power-down until the wake line is released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wakeHold <= 1'b0;
    else if (pdMode)   wakeHold <= 1'b1;
    else if (wakeIntN) wakeHold <= 1'b0;
  end

  // reset pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pulseCnt <= '0;
    else if (ovf)     pulseCnt <= PLEN;
    else if (inPulse) pulseCnt <= pulseCnt - ONE;
  end

  assign rstOut = inPulse;

  // R5
  no_soft_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enabled) |-> rstOut);

  // R8
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdMode |-> !strb.inc);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pdMode) && !pdMode && !wakeIntN) |-> !strb.inc);

  // R10
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleMode && idleFreeze) |-> !strb.inc);

  // R6
  pulse_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> (strb.clr && !strb.inc));
endmodule

// File: rtl/seq_watchdog.sv
`timescale 1ns/1ps
module seq_watchdog
  import seq_wdt_pkg::*;
#(
  parameter int                CNT_W     = 13,
  parameter int                PULSE_LEN = 98,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 'hA6,
  parameter logic [DATA_W-1:0] KEY_A     = 'h1E,
  parameter logic [DATA_W-1:0] KEY_B     = 'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrData,
  input  logic              sfrWe,
  input  logic              idleMode,
  input  logic              pdMode,
  input  logic              idleFreeze,
  input  logic              wakeIntN,
  output logic              rstOut
);
  wdtStrb_t strb;
  logic     atLimit;

  seq_wdt_ctrl #(
    .PULSE_LEN(PULSE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SVC_ADDR(SVC_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe),
    .sfrAddr(sfrAddr), .sfrData(sfrData), .sfrWe(sfrWe),
    .idleMode(idleMode), .pdMode(pdMode), .idleFreeze(idleFreeze),
    .wakeIntN(wakeIntN), .atLimit(atLimit), .strb(strb), .rstOut(rstOut)
  );

  seq_wdt_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .atLimit(atLimit)
  );
endmodule

// File: tb/seq_watchdog_tb.sv
`timescale 1ns/1ps
module seq_watchdog_tb;
  localparam int         CW   = 4;
  localparam int         LEN  = 5;
  localparam int         MAXV = (1 << CW) - 1;   // counted cycles to overflow
  localparam logic [7:0] SA   = 8'hA6;
  localparam logic [7:0] KA   = 8'h1E;
  localparam logic [7:0] KB   = 8'hE1;

  logic clk = 1'b0;
  logic rstN = 1'b0, mc = 1'b0, we = 1'b0;
  logic idle = 1'b0, pd = 1'b0, frz = 1'b0, wk = 1'b1;
  logic [7:0] addr = 8'h00, data = 8'h00;
  logic rstOut;

  always #10 clk = ~clk;

  seq_watchdog #(.CNT_W(CW), .PULSE_LEN(LEN)) u_dut (
    .clk(clk), .rstN(rstN), .mcStrobe(mc), .sfrAddr(addr), .sfrData(data),
    .sfrWe(we), .idleMode(idle), .pdMode(pd), .idleFreeze(frz),
    .wakeIntN(wk), .rstOut(rstOut)
  );

  int vecs = 0, bad = 0;
  string req = "R1";

  // behavioural expectation, built from the requirement text
  int mCnt = 0, mPulse = 0;
  bit mEn = 0, mArm = 0, mHold = 0;

  task automatic chk(input string r, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    bit hit, tk;
    @(posedge clk);
    if (!rstN) begin
      mCnt = 0; mPulse = 0; mEn = 0; mArm = 0; mHold = 0;
    end else begin
      hit = we && addr == SA && mArm && data == KB;
      if (mPulse > 0) begin
        mPulse--; mEn = 0; mCnt = 0; mArm = 0;
      end else begin
        tk = mEn && mc && !pd && !mHold && !(idle && frz);
        if (hit) begin mEn = 1; mCnt = 0; end
        else if (tk) begin
          if (mCnt == MAXV - 1) begin mPulse = LEN; mEn = 0; mCnt = 0; end
          else mCnt++;
        end
        if (we && addr == SA) mArm = (data == KA);
      end
      if (pd) mHold = 1; else if (wk) mHold = 0;
    end
    @(negedge clk);
    chk(req, int'(rstOut), int'(mPulse != 0));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic m);
    addr = a; data = d; we = 1'b1; mc = m;
    step();
    we = 1'b0; mc = 1'b0;
  endtask

  task automatic run(input int n, input logic m);
    mc = m;
    for (int i = 0; i < n; i++) step();
    mc = 1'b0;
  endtask

  task automatic untilPulse(input int lim, output int n);
    n = 0; mc = 1'b1;
    while (!rstOut && n < lim) begin step(); n++; end
    mc = 1'b0;
  endtask

  task automatic pulseWidth(output int w);
    w = 0;
    while (rstOut && w < LEN + 10) begin step(); w++; end
  endtask

  task automatic hwReset();
    rstN = 1'b0; idle = 0; pd = 0; frz = 0; wk = 1; mc = 0; we = 0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic unlock();
    wr(SA, KA, 1'b0); wr(SA, KB, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #4ms;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n, w;
    @(negedge clk);
    req = "R1"; hwReset();
    chk("R1", int'(rstOut), 0);
    run(3 * MAXV, 1'b1);
    chk("R1", int'(rstOut), 0);

    // R2 / R3 / R6: enable, overflow after MAXV counted cycles, pulse length
    req = "R2"; unlock();
    req = "R3"; untilPulse(4 * MAXV, n);
    chk("R3", n, MAXV);
    req = "R6"; pulseWidth(w);
    chk("R6", w, LEN);

    // R5: disabled after the pulse
    req = "R5"; run(3 * MAXV, 1'b1);
    chk("R5", int'(rstOut), 0);

    // R6: keys written inside the pulse are lost
    req = "R6"; unlock(); run(MAXV - 1, 1'b1);
    mc = 1'b1; step(); mc = 1'b0;
    chk("R6", int'(rstOut), 1);
    wr(SA, KA, 1'b0); wr(SA, KB, 1'b0);
    pulseWidth(w);
    run(3 * MAXV, 1'b1);
    chk("R6", int'(rstOut), 0);

    // R4: service clears, and beats an overflow in the same cycle
    req = "R4"; hwReset(); unlock();
    run(MAXV - 2, 1'b1);
    wr(SA, KA, 1'b1); wr(SA, KB, 1'b1);
    run(MAXV - 1, 1'b1);
    chk("R4", int'(rstOut), 0);
    hwReset(); unlock();
    run(MAXV - 1, 1'b1);
    wr(SA, KA, 1'b0);
    wr(SA, KB, 1'b1);            // collides with the final counted cycle
    chk("R4", int'(rstOut), 0);
    untilPulse(4 * MAXV, n);
    chk("R4", n, MAXV);
    pulseWidth(w);

    // R11: abort, re-arm, lone KEY_B
    req = "R11"; hwReset();
    wr(SA, KB, 1'b0);
    run(3 * MAXV, 1'b1);
    chk("R11", int'(rstOut), 0);
    unlock(); run(MAXV - 5, 1'b1);
    wr(SA, KA, 1'b0); wr(SA, 8'h55, 1'b0); wr(SA, KB, 1'b0);
    untilPulse(4 * MAXV, n);
    chk("R11", n, 5);
    pulseWidth(w);
    unlock(); run(MAXV - 5, 1'b1);
    wr(SA, KA, 1'b0); wr(SA, KA, 1'b0); wr(SA, KB, 1'b0);
    untilPulse(4 * MAXV, n);
    chk("R11", n, MAXV);
    pulseWidth(w);

    // R12: other addresses do not disturb the tracker or counter
    req = "R12"; hwReset();
    wr(SA, KA, 1'b0); wr(8'hA7, 8'h00, 1'b0); wr(8'h26, KB, 1'b0); wr(SA, KB, 1'b0);
    run(MAXV - 3, 1'b1);
    wr(8'hA6 ^ 8'h80, KA, 1'b1); wr(8'hA6 ^ 8'h01, KB, 1'b1);
    untilPulse(4 * MAXV, n);
    chk("R12", n, 1);
    pulseWidth(w);

    // R7: strobe every third clock
    req = "R7"; hwReset(); unlock();
    n = 0;
    while (!rstOut && n < 10 * MAXV) begin
      mc = (n % 3 == 2); step(); n++;
    end
    mc = 1'b0;
    chk("R7", n, 3 * MAXV);
    pulseWidth(w);

    // R9: held after power-down until the wake line rises
    req = "R9"; hwReset(); unlock();
    pd = 1'b1; wk = 1'b0; run(4, 1'b1);
    pd = 1'b0; run(3 * MAXV, 1'b1);
    chk("R9", int'(rstOut), 0);
    wk = 1'b1; step();
    untilPulse(4 * MAXV, n);
    chk("R9", n, MAXV);
    pulseWidth(w);

    // R8 / R10: sweep all mode-flag combinations
    for (int c = 0; c < 16; c++) begin
      req = "R8/R10"; hwReset(); unlock();
      idle = c[0]; frz = c[1]; pd = c[2]; wk = c[3];
      run(MAXV + 2, 1'b1);
      chk(c[2] ? "R8" : "R10", int'(rstOut), int'(!(c[2] || (c[0] && c[1]))));
      idle = 0; frz = 0; pd = 0; wk = 1;
      run(2 * MAXV, 1'b1);
    end

    summary();
  end
endmodule